// File: doc/BRIEF.md
# Word-Addressed Serial Port with Single Divisor Register

This block is a serial transmitter and receiver for 8-bit characters. A processor reaches it through a plain register port: an address that selects one 32-bit word, a write enable with write data, and a read strobe. Read data is combinational from the address. Characters leave on `txd` and arrive on `rxd`. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Bit timing comes from a tick that runs at sixteen times the bit rate. One 16-bit divisor register sets the tick period. Software picks the divisor as the input clock divided by sixteen times the baud rate, rounded to the nearest integer.

Transmit and receive each have a small FIFO. When the FIFOs are disabled, each one holds a single character. Software can flush either FIFO through self-clearing bits. A line status word reports received data, overrun, holding-stage room and an idle transmitter. Two modem-control bits drive the `dtr` and `rts` pins directly.

Top module: `wuart`

## Requirements
- R1: Word index selects the register: 0 receive data, 1 transmit data, 2 interrupt enable (4 bits), 3 interrupt identity (reads 1), 4 FIFO control, 5 line control, 6 modem control, 7 line status, 8 modem status (reads 0), 9 scratch, 10 divisor, 11 divisor low byte, 12 divisor high byte, 13 interface control (reads 0).
- R2: Word 10 takes and returns the full 16-bit divisor in one access. Words 11 and 12 read and write its low and high bytes. The divisor resets to 1.
- R3: A transmitted frame is start bit 0, eight data bits LSB first, then stop bit 1. Each bit lasts 16 × divisor clock cycles, and `txd` idles high.
- R4: Line status bit 5 is 1 while the transmit FIFO has room. Room is 4 entries when FIFOs are enabled and 1 when they are disabled. A transmit write made while there is no room is dropped and never sent.
- R5: Line status bit 6 is 1 only when the transmit FIFO is empty and the shifter is idle.
- R6: Line status bit 0 is 1 while any received character is held. A read of word 0 returns the oldest character and removes it.
- R7: In FIFO control, bit 0 enables the FIFOs and reads back. Writing bit 1 empties the receive FIFO, and writing bit 2 empties the transmit FIFO without touching the character being shifted. Bits 1 and 2 always read 0.
- R8: Modem control bit 0 drives `dtr` and bit 1 drives `rts`. Both are 0 after reset.
- R9: Line control resets to 0x03, meaning 8 data bits and 1 stop bit. Line control and scratch read back what was written.
- R10: The receiver samples each bit 8 ticks into it. A start bit that has returned high by that point is discarded, and no character results.
- R11: A character that completes while the receive FIFO is full is dropped, and line status bit 1 is set. Reading line status clears that bit.
- R12: After reset, line status reads 0x60 and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register word index |
| we | input | 1 | Write enable |
| rd | input | 1 | Read strobe; pops receive data or clears overrun |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| dtr | output | 1 | Modem control bit 0 |
| rts | output | 1 | Modem control bit 1 |

## Verification
Register reads are combinational, so the bench drives the address at a falling edge and samples `rdata` before the next rising edge. It checks register-write effects one cycle after the write edge. A transmit start bit appears one cycle after a character is accepted. A serial monitor is launched before any transmit write, so it sees that falling edge. It then samples each bit 8 × divisor cycles after the bit begins, which keeps every sample clear of tick-alignment jitter. The receiver stores a character at the middle of the stop bit, two synchroniser cycles after that point. The bench therefore reads data and line status only after it has driven the whole stop bit.

// File: rtl/wuart.sv
module wuart #(
  parameter int          DEPTH    = 4,
  parameter logic [15:0] DIV_INIT = 16'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  addr,
  input  logic        we,
  input  logic        rd,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        txd,
  input  logic        rxd,
  output logic        dtr,
  output logic        rts
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [3:0]  ier;
  logic [7:0]  lcr, scr;
  logic [1:0]  mcr;
  logic [15:0] div, bcnt;
  logic        fen, ovr;

  wire wr_thr = we && addr == 4'd1;
  wire wr_ier = we && addr == 4'd2;
  wire wr_fcr = we && addr == 4'd4;
  wire wr_lcr = we && addr == 4'd5;
  wire wr_mcr = we && addr == 4'd6;
  wire wr_scr = we && addr == 4'd9;
  wire wr_div = we && addr == 4'd10;
  wire wr_dl  = we && addr == 4'd11;
  wire wr_dh  = we && addr == 4'd12;
  wire [CW-1:0] cap = fen ? CW'(DEPTH) : CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ier <= '0; lcr <= 8'h03; scr <= '0; mcr <= '0; div <= DIV_INIT; fen <= 1'b0;
    end else begin
      if (wr_ier) ier <= wdata[3:0];
      if (wr_lcr) lcr <= wdata[7:0];
      if (wr_scr) scr <= wdata[7:0];
      if (wr_mcr) mcr <= wdata[1:0];
      if (wr_fcr) fen <= wdata[0];
      if (wr_div) div <= wdata[15:0];
      if (wr_dl)  div[7:0] <= wdata[7:0];
      if (wr_dh)  div[15:8] <= wdata[7:0];
    end

  assign dtr = mcr[0];
  assign rts = mcr[1];

  wire tick = bcnt == 16'd0;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else if (wr_div || wr_dl || wr_dh) bcnt <= '0;
    else if (tick) bcnt <= div - 16'd1;
    else bcnt <= bcnt - 16'd1;

  // transmit FIFO and shifter
  logic [7:0]    tmem [DEPTH];
  logic [AW-1:0] twp, trp;
  logic [CW-1:0] tcnt;
  logic          tbusy;
  logic [9:0]    tsh;
  logic [3:0]    tbit, tph;

  wire tpush = wr_thr && tcnt < cap;
  wire tload = !tbusy && tcnt != '0;
  wire tclr  = wr_fcr && wdata[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else if (tclr) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else begin
      if (tpush) twp <= twp + 1'b1;
      if (tload) trp <= trp + 1'b1;
      tcnt <= tcnt + CW'(tpush) - CW'(tload);
    end

  always_ff @(posedge clk)
    if (tpush && !tclr) tmem[twp] <= wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tbusy <= 1'b0; tsh <= '1; tbit <= '0; tph <= '0;
    end else if (tload) begin
      tbusy <= 1'b1; tsh <= {1'b1, tmem[trp], 1'b0}; tbit <= '0; tph <= '0;
    end else if (tbusy && tick) begin
      tph <= tph + 4'd1;
      if (tph == 4'd15) begin
        tsh <= {1'b1, tsh[9:1]};
        if (tbit == 4'd9) tbusy <= 1'b0;
        else tbit <= tbit + 4'd1;
      end
    end

  assign txd = tbusy ? tsh[0] : 1'b1;

  // receive synchroniser, shifter and FIFO
  logic          rs1, rs2, rbusy;
  logic [3:0]    rbit, rph;
  logic [7:0]    rsh;
  logic [7:0]    rmem [DEPTH];
  logic [AW-1:0] rwp, rrp;
  logic [CW-1:0] rcnt;

  wire rmid  = rbusy && tick && rph == 4'd7;
  wire rdone = rmid && rbit == 4'd9;
  wire rpush = rdone && rcnt < cap;
  wire rpop  = rd && addr == 4'd0 && rcnt != '0;
  wire rclr  = wr_fcr && wdata[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1; rbusy <= 1'b0; rbit <= '0; rph <= '0; rsh <= '0;
    end else begin
      rs1 <= rxd;
      rs2 <= rs1;
      if (!rbusy) begin
        if (tick && !rs2) begin
          rbusy <= 1'b1; rbit <= '0; rph <= '0;
        end
      end else if (tick) begin
        rph <= rph + 4'd1;
        if (rph == 4'd15) rbit <= rbit + 4'd1;
        if (rph == 4'd7) begin
          if (rbit == 4'd0 && rs2) rbusy <= 1'b0;
          else if (rbit == 4'd9) rbusy <= 1'b0;
          else if (rbit != 4'd0) rsh <= {rs2, rsh[7:1]};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else if (rclr) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (rpush) rwp <= rwp + 1'b1;
      if (rpop)  rrp <= rrp + 1'b1;
      rcnt <= rcnt + CW'(rpush) - CW'(rpop);
    end

  always_ff @(posedge clk)
    if (rpush && !rclr) rmem[rwp] <= rsh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovr <= 1'b0;
    else if (rdone && !rpush) ovr <= 1'b1;
    else if (rd && addr == 4'd7) ovr <= 1'b0;

  wire thre = tcnt < cap;
  wire temt = tcnt == '0 && !tbusy;
  wire [7:0] lsr = {1'b0, temt, thre, 3'b000, ovr, rcnt != '0};

  always_comb
    case (addr)
      4'd0:    rdata = {24'd0, rmem[rrp]};
      4'd2:    rdata = {28'd0, ier};
      4'd3:    rdata = 32'd1;
      4'd4:    rdata = {31'd0, fen};
      4'd5:    rdata = {24'd0, lcr};
      4'd6:    rdata = {30'd0, mcr};
      4'd7:    rdata = {24'd0, lsr};
      4'd9:    rdata = {24'd0, scr};
      4'd10:   rdata = {16'd0, div};
      4'd11:   rdata = {24'd0, div[7:0]};
      4'd12:   rdata = {24'd0, div[15:8]};
      default: rdata = 32'd0;
    endcase
endmodule

// File: rtl/wuart_chk.sv
module wuart_chk #(parameter int DEPTH = 4) (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic [3:0]  addr,
  input logic [31:0] wdata,
  input logic        txd,
  input logic        dtr,
  input logic        rts,
  input logic        tbusy,
  input logic [$clog2(DEPTH):0] tcnt,
  input logic [$clog2(DEPTH):0] rcnt,
  input logic [15:0] div
);
  // R8
  mcr_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'd6) |=> (dtr == $past(wdata[0]) && rts == $past(wdata[1])));
  // R2
  div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'd10) |=> div == $past(wdata[15:0]));
  // R3
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbusy |-> txd);
  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt <= ($clog2(DEPTH)+1)'(DEPTH)) && (rcnt <= ($clog2(DEPTH)+1)'(DEPTH)));
  // R5
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tbusy && tcnt != '0 && !(we && addr == 4'd4 && wdata[2])) |=> tbusy);
endmodule

bind wuart wuart_chk #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .txd(txd), .dtr(dtr), .rts(rts), .tbusy(tbusy), .tcnt(tcnt),
  .rcnt(rcnt), .div(div));

// File: tb/wuart_test.sv
module wuart_test;
  logic clk = 0, rst_n = 0, we = 0, rd = 0, rxd = 1;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic txd, dtr, rts;
  int nchk = 0, nfail = 0, ncap = 0;
  logic [7:0] got [16];
  bit done = 0;

  wuart uut (.clk, .rst_n, .addr, .we, .rd, .wdata, .rdata, .txd, .rxd, .dtr, .rts);

  always #5 clk = ~clk;

  function automatic logic [31:0] lsr_of(bit dr, bit ov, bit thre, bit temt);
    return {25'd0, temt, thre, 3'd0, ov, dr};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rdreg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic cap_frames(int n, int d);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      while (txd) @(negedge clk);
      repeat (8*d) @(negedge clk);
      chk("R3 start bit", txd, 0);
      for (int b = 0; b < 8; b++) begin
        repeat (16*d) @(negedge clk);
        v[b] = txd;
      end
      repeat (16*d) @(negedge clk);
      chk("R3 stop bit", txd, 1);
      got[ncap++] = v;
    end
  endtask

  task automatic send_rx(logic [7:0] v, int d);
    logic [9:0] f = {1'b1, v, 1'b0};
    for (int b = 0; b < 10; b++) begin
      @(negedge clk); rxd = f[b];
      repeat (16*d - 1) @(negedge clk);
    end
  endtask

  task automatic quiet(string req, int n);
    bit low = 0;
    repeat (n) begin @(negedge clk); if (!txd) low = 1; end
    chk(req, low, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] b [8];
    r = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 txd idle", txd, 1);
    rdreg(7, r); chk("R12 lsr reset", r, 32'h60);
    rdreg(5, r); chk("R9 lcr reset", r, 32'h03);
    rdreg(10, r); chk("R2 divisor reset", r, 1);
    chk("R8 pins reset", {dtr, rts}, 0);
    rdreg(3, r); chk("R1 iir", r, 1);
    rdreg(8, r); chk("R1 msr", r, 0);

    b[0] = 8'($urandom);
    wr(9, b[0]); rdreg(9, r); chk("R9 scratch", r, b[0]);
    wr(5, 32'h1b); rdreg(5, r); chk("R9 lcr", r, 32'h1b);
    wr(5, 32'h03);
    wr(2, 32'hff); rdreg(2, r); chk("R1 ier", r, 32'hf);
    wr(6, 3); chk("R8 dtr rts", {dtr, rts}, 2'b11);
    wr(6, 1); chk("R8 dtr only", {dtr, rts}, 2'b10);

    wr(10, 32'h1234); rdreg(10, r); chk("R2 divisor", r, 32'h1234);
    rdreg(11, r); chk("R2 low byte", r, 32'h34);
    rdreg(12, r); chk("R2 high byte", r, 32'h12);
    wr(11, 5); rdreg(10, r); chk("R2 low write", r, 32'h1205);
    wr(10, 1);

    wr(4, 7); rdreg(4, r); chk("R7 fcr readback", r, 1);

    for (int d = 1; d <= 2; d++) begin
      wr(10, d);
      for (int i = 0; i < 3; i++) begin
        logic [7:0] x = 8'($urandom);
        ncap = 0;
        fork cap_frames(1, d); join_none
        wr(1, x);
        wait fork;
        chk("R3 tx data", got[0], x);
        repeat (16*d) @(negedge clk);
        rdreg(7, r); chk("R5 idle lsr", r, 32'h60);
      end
    end

    wr(10, 1);
    ncap = 0;
    for (int i = 0; i < 6; i++) b[i] = 8'($urandom);
    fork cap_frames(5, 1); join_none
    wr(1, b[0]);
    rdreg(7, r); chk("R5 temt low while busy", r[6], 0);
    for (int i = 1; i < 5; i++) wr(1, b[i]);
    rdreg(7, r); chk("R4 fifo full", r[5], 0);
    wr(1, b[5]);
    wait fork;
    for (int i = 0; i < 5; i++) chk("R4 fifo order", got[i], b[i]);
    quiet("R4 dropped write", 300);

    wr(4, 0);
    ncap = 0;
    fork cap_frames(2, 1); join_none
    wr(1, b[0]);
    @(negedge clk);
    rdreg(7, r); chk("R4 single room", r[5], 1);
    wr(1, b[1]);
    rdreg(7, r); chk("R4 single full", r[5], 0);
    wr(1, b[2]);
    wait fork;
    chk("R4 nofifo first", got[0], b[0]);
    chk("R4 nofifo second", got[1], b[1]);
    quiet("R4 nofifo drop", 300);

    wr(4, 1);
    ncap = 0;
    fork cap_frames(1, 1); join_none
    wr(1, b[3]); wr(1, b[4]); wr(1, b[5]);
    wr(4, 5);
    wait fork;
    chk("R7 tx clear keeps shifter", got[0], b[3]);
    quiet("R7 tx clear", 300);

    for (int i = 0; i < 20; i++) begin
      int d = 1 + int'($urandom % 3);
      logic [7:0] x = 8'($urandom);
      wr(10, d);
      send_rx(x, d);
      repeat (4) @(negedge clk);
      rdreg(7, r); chk("R6 data ready", r, lsr_of(1, 0, 1, 1));
      rdreg(0, r); chk("R6 rx data", r, x);
      rdreg(7, r); chk("R6 ready clears", r[0], 0);
    end

    wr(10, 1);
    for (int i = 0; i < 3; i++) begin b[i] = 8'($urandom); send_rx(b[i], 1); end
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin rdreg(0, r); chk("R6 rx order", r, b[i]); end
    rdreg(7, r); chk("R6 empty", r, 32'h60);

    send_rx(8'h5a, 1); send_rx(8'ha5, 1);
    repeat (4) @(negedge clk);
    wr(4, 3);
    rdreg(7, r); chk("R7 rx clear", r, 32'h60);
    rdreg(4, r); chk("R7 clear bits read 0", r, 1);

    @(negedge clk); rxd = 0;
    repeat (4) @(negedge clk); rxd = 1;
    repeat (300) @(negedge clk);
    rdreg(7, r); chk("R10 glitch dropped", r, 32'h60);
    send_rx(8'hc3, 1);
    repeat (4) @(negedge clk);
    rdreg(0, r); chk("R10 after glitch", r, 32'hc3);

    wr(4, 0);
    send_rx(8'h11, 1); send_rx(8'h22, 1);
    repeat (4) @(negedge clk);
    rdreg(7, r); chk("R11 overrun set", r, lsr_of(1, 1, 1, 1));
    rdreg(7, r); chk("R11 overrun cleared", r, lsr_of(1, 0, 1, 1));
    rdreg(0, r); chk("R11 first kept", r, 32'h11);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule